// File: doc/BRIEF.md
# Three-Address Load/Store Processor Core

A multicycle 32-bit processor core for a compact fixed-format instruction set. Every instruction is one 32-bit word holding a 6-bit opcode, two 5-bit register selectors and a 16-bit field. That last field carries a third register number, an absolute address, a displacement or a sign-extended immediate, depending on the opcode. The core holds 32 general registers, with register 0 wired to zero. It has no condition flags. Comparisons write 1 or 0 into a register, and conditional jumps test whether a register is zero.

A single word-addressed memory port serves both instruction fetch and data access. Each instruction goes through fetch, decode and execute, and some instructions take one or two further steps for memory or register writeback. Arithmetic, logic, compare and shift work is handed to a separate ALU unit through a start/done handshake. The ALU latency is a parameter. A trap instruction can stop the core or put a register value on a one-cycle print output. An opcode that is not defined raises an illegal flag and stops the core.

Top module: `tac_core`

## Requirements
- R1: Register 0 always reads as zero, and any write aimed at it is discarded.
- R2: Register-form operations take opcodes 32..47 and write R[r1] = R[r2] op R[r3], where r3 is d[4:0]. The opcodes in order are add, sub, mul, div, and, or, xor, eq, ne, lt, le, gt, ge, shl, shr, mod. Compares are signed two's complement and give 1 or 0. Shifts use the low 5 bits of the second operand, and shr is logical. div and mod truncate toward zero, and both give 0 for a zero divisor.
- R3: Immediate-form operations take opcodes 10..25, in the same order as R2. The second operand is d sign-extended to 32 bits.
- R4: Opcode 1 loads R[r1] and opcode 3 stores R[r1], both at the word address formed by zero-extending d.
- R5: Opcode 2 loads R[r1] and opcode 4 stores R[r1], both at address R[r2] + sign-extended d.
- R6: Opcode 48 loads R[r1] and opcode 49 stores R[r1], both at address R[r2] + R[r3]. All 32 address bits reach the memory port.
- R7: Opcode 6 sets PC to the zero-extended d. Opcode 8 does the same only when R[r1] is nonzero, and opcode 9 only when R[r1] is zero.
- R8: Opcode 7 writes the address of the following instruction into R[r1] and jumps to d. Opcode 50 loads PC from R[r1].
- R9: Opcode 52 (push) adds one to R[r1] and then stores R[r2] at the new R[r1]. Opcode 53 (pop) loads R[r2] from M[R[r1]] and then subtracts one from R[r1].
- R10: Opcode 51 with d=0 stops the core: `halted` stays high and no further memory access occurs. With d=1 it raises `print_valid` for exactly one cycle, with `print_data` = R[r1]. Any other d value has no effect.
- R11: Opcodes 0 and 5 do nothing, whatever their other fields hold. Opcodes 26..31 and 54..63 set `illegal` and stop the core without changing any register or memory word.
- R12: After reset the first access is a fetch of word 0. Read data is taken from `mem_rdata` one cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Word address for fetch, load or store |
| mem_rd | output | 1 | Read request; data is expected on `mem_rdata` in the next cycle |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| halted | output | 1 | High once the core has stopped |
| illegal | output | 1 | High once an undefined opcode has been executed |
| print_valid | output | 1 | One-cycle strobe from the print trap |
| print_data | output | 32 | Register value presented with `print_valid` |

## Verification
The bench builds the core with `ALU_LAT` = 3. This exercises the counting variant of the ALU handshake rather than the single-flop one, so a missed or repeated `done` would corrupt results. The bench memory is a 1024-word array indexed by the low ten address bits. Because of this aliasing, a store to a high index address can be checked both at the port and in the array. Every ALU operation is swept in both register and immediate form over a 6x6 grid of edge operands: zero, ±1, extremes, shift amounts past 31 and zero divisors. All sixteen undefined opcodes are tried one by one.

// File: rtl/tac_pkg.sv
package tac_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned RSEL_W = 5;
   localparam int unsigned OPC_W  = 6;
   localparam int unsigned IMM_W  = 16;

   typedef struct packed {
      logic [OPC_W-1:0]  opc;
      logic [RSEL_W-1:0] ra;
      logic [RSEL_W-1:0] rb;
      logic [IMM_W-1:0]  dfield;
   } insn_t;

   // order fixed by the opcode encoding: index = opc - first opcode of the group
   typedef enum logic [3:0] {
      FN_ADD, FN_SUB, FN_MUL, FN_DIV, FN_AND, FN_OR,  FN_XOR, FN_EQ,
      FN_NE,  FN_LT,  FN_LE,  FN_GT,  FN_GE,  FN_SHL, FN_SHR, FN_MOD
   } alu_fn_e;

   typedef enum logic [2:0] {
      ST_FETCH, ST_DECODE, ST_EXEC, ST_ALU, ST_LOADWB, ST_PUSHST, ST_POPDEC, ST_HALT
   } core_st_e;

   localparam logic [OPC_W-1:0] OP_NOP_A   = 6'd0;
   localparam logic [OPC_W-1:0] OP_LD_ABS  = 6'd1;
   localparam logic [OPC_W-1:0] OP_LD_DSP  = 6'd2;
   localparam logic [OPC_W-1:0] OP_ST_ABS  = 6'd3;
   localparam logic [OPC_W-1:0] OP_ST_DSP  = 6'd4;
   localparam logic [OPC_W-1:0] OP_NOP_B   = 6'd5;
   localparam logic [OPC_W-1:0] OP_JMP     = 6'd6;
   localparam logic [OPC_W-1:0] OP_LINK    = 6'd7;
   localparam logic [OPC_W-1:0] OP_JNZ     = 6'd8;
   localparam logic [OPC_W-1:0] OP_JZ      = 6'd9;
   localparam logic [OPC_W-1:0] OP_IMM_LO  = 6'd10;
   localparam logic [OPC_W-1:0] OP_IMM_HI  = 6'd25;
   localparam logic [OPC_W-1:0] OP_REG_LO  = 6'd32;
   localparam logic [OPC_W-1:0] OP_REG_HI  = 6'd47;
   localparam logic [OPC_W-1:0] OP_LD_IDX  = 6'd48;
   localparam logic [OPC_W-1:0] OP_ST_IDX  = 6'd49;
   localparam logic [OPC_W-1:0] OP_RET     = 6'd50;
   localparam logic [OPC_W-1:0] OP_TRAP    = 6'd51;
   localparam logic [OPC_W-1:0] OP_PUSH    = 6'd52;
   localparam logic [OPC_W-1:0] OP_POP     = 6'd53;

   localparam logic [IMM_W-1:0] TRAP_STOP  = 16'd0;
   localparam logic [IMM_W-1:0] TRAP_PRINT = 16'd1;

endpackage

// File: rtl/tac_regfile.sv
module tac_regfile #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned SEL_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel_a,
   input  logic [SEL_W-1:0]  sel_b,
   input  logic [SEL_W-1:0]  sel_c,
   output logic [WORD_W-1:0] val_a,
   output logic [WORD_W-1:0] val_b,
   output logic [WORD_W-1:0] val_c,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [WORD_W-1:0] wr_val
);
   localparam int unsigned NREG = 1 << SEL_W;

   initial begin
      assert (SEL_W >= 1 && SEL_W <= 6) else $error("tac_regfile: SEL_W out of range");
      assert (WORD_W >= 8) else $error("tac_regfile: WORD_W too small");
   end

   logic [WORD_W-1:0] bank [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_entry
      if (i == 0) begin : g_zero
         assign bank[i] = '0;
      end else begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bank[i] <= '0;
            else if (wr_en && wr_sel == SEL_W'(i))
               bank[i] <= wr_val;
         end
      end
   end

   assign val_a = bank[sel_a];
   assign val_b = bank[sel_b];
   assign val_c = bank[sel_c];

endmodule

// File: rtl/tac_alu.sv
module tac_alu
   import tac_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned LAT    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  alu_fn_e           fn,
   input  logic [WORD_W-1:0] opa,
   input  logic [WORD_W-1:0] opb,
   output logic              done,
   output logic              busy,
   output logic [WORD_W-1:0] res
);
   localparam int unsigned SH_W = $clog2(WORD_W);

   initial begin
      assert (LAT >= 1 && LAT <= 64) else $error("tac_alu: LAT must be 1..64");
      assert ((1 << SH_W) == WORD_W) else $error("tac_alu: WORD_W must be a power of two");
   end

   logic signed [WORD_W-1:0] sa, sb;
   logic        [WORD_W-1:0] y;
   logic                     zero_div;

   assign sa       = opa;
   assign sb       = opb;
   assign zero_div = (opb == '0);

   always_comb begin
      case (fn)
         FN_ADD:  y = opa + opb;
         FN_SUB:  y = opa - opb;
         FN_MUL:  y = opa * opb;
         FN_DIV:  y = zero_div ? '0 : WORD_W'(sa / sb);
         FN_AND:  y = opa & opb;
         FN_OR:   y = opa | opb;
         FN_XOR:  y = opa ^ opb;
         FN_EQ:   y = WORD_W'(opa == opb);
         FN_NE:   y = WORD_W'(opa != opb);
         FN_LT:   y = WORD_W'(sa <  sb);
         FN_LE:   y = WORD_W'(sa <= sb);
         FN_GT:   y = WORD_W'(sa >  sb);
         FN_GE:   y = WORD_W'(sa >= sb);
         FN_SHL:  y = opa << opb[SH_W-1:0];
         FN_SHR:  y = opa >> opb[SH_W-1:0];
         FN_MOD:  y = zero_div ? '0 : WORD_W'(sa % sb);
         default: y = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     res <= '0;
      else if (start) res <= y;
   end

   if (LAT == 1) begin : g_single
      logic done_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) done_q <= 1'b0;
         else        done_q <= start;
      end
      assign done = done_q;
      assign busy = 1'b0;
   end else begin : g_multi
      localparam int unsigned CNT_W = $clog2(LAT + 1);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (start)      cnt <= CNT_W'(LAT);
         else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign done = (cnt == CNT_W'(1));
      assign busy = (cnt > CNT_W'(1));
   end

   // R2: one done per start, never two in a row
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   // R2: the caller never restarts an operation still in flight
   p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !start);

endmodule

// File: rtl/tac_core.sv
module tac_core
   import tac_pkg::*;
#(
   parameter int unsigned ALU_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [WORD_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              halted,
   output logic              illegal,
   output logic              print_valid,
   output logic [WORD_W-1:0] print_data
);
   localparam int unsigned EXT_W = WORD_W - IMM_W;

   initial begin
      assert (WORD_W == OPC_W + 2*RSEL_W + IMM_W) else $error("tac_core: field widths do not fill a word");
      assert (ALU_LAT >= 1) else $error("tac_core: ALU_LAT must be at least 1");
   end

   core_st_e          st, st_nxt;
   insn_t             ir;
   logic [WORD_W-1:0] pc, pc_nxt;
   logic              illegal_q, illegal_nxt;
   logic              pv_nxt;

   logic [WORD_W-1:0] rv1, rv2, rv3;
   logic              rf_we;
   logic [RSEL_W-1:0] rf_wsel;
   logic [WORD_W-1:0] rf_wval;

   logic              alu_start, alu_done, alu_busy;
   alu_fn_e           alu_fn;
   logic [WORD_W-1:0] alu_b, alu_res;

   logic [WORD_W-1:0] sext_d, zext_d, eff_addr;
   logic              is_imm, is_reg, is_undef;

   assign sext_d   = {{EXT_W{ir.dfield[IMM_W-1]}}, ir.dfield};
   assign zext_d   = {{EXT_W{1'b0}}, ir.dfield};
   assign is_imm   = (ir.opc >= OP_IMM_LO) && (ir.opc <= OP_IMM_HI);
   assign is_reg   = (ir.opc >= OP_REG_LO) && (ir.opc <= OP_REG_HI);
   assign is_undef = ((ir.opc > OP_IMM_HI) && (ir.opc < OP_REG_LO)) || (ir.opc > OP_POP);
   // both groups share the low-nibble order; immediate group starts at 10
   assign alu_fn   = alu_fn_e'(is_imm ? ir.opc[3:0] - 4'd10 : ir.opc[3:0]);
   assign alu_b    = is_imm ? sext_d : rv3;

   always_comb begin
      case (ir.opc)
         OP_LD_ABS, OP_ST_ABS: eff_addr = zext_d;
         OP_LD_DSP, OP_ST_DSP: eff_addr = rv2 + sext_d;
         OP_LD_IDX, OP_ST_IDX: eff_addr = rv2 + rv3;
         default:              eff_addr = rv1;
      endcase
   end

   tac_regfile #(.WORD_W(WORD_W), .SEL_W(RSEL_W)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_a  (ir.ra),
      .sel_b  (ir.rb),
      .sel_c  (ir.dfield[RSEL_W-1:0]),
      .val_a  (rv1),
      .val_b  (rv2),
      .val_c  (rv3),
      .wr_en  (rf_we),
      .wr_sel (rf_wsel),
      .wr_val (rf_wval)
   );

   tac_alu #(.WORD_W(WORD_W), .LAT(ALU_LAT)) u_alu (
      .clk   (clk),
      .rst_n (rst_n),
      .start (alu_start),
      .fn    (alu_fn),
      .opa   (rv2),
      .opb   (alu_b),
      .done  (alu_done),
      .busy  (alu_busy),
      .res   (alu_res)
   );

   always_comb begin
      st_nxt      = st;
      pc_nxt      = pc;
      illegal_nxt = illegal_q;
      pv_nxt      = 1'b0;
      mem_rd      = 1'b0;
      mem_wr      = 1'b0;
      mem_addr    = pc;
      mem_wdata   = rv1;
      rf_we       = 1'b0;
      rf_wsel     = ir.ra;
      rf_wval     = alu_res;
      alu_start   = 1'b0;
      case (st)
         ST_FETCH: begin
            mem_rd = 1'b1;
            st_nxt = ST_DECODE;
         end
         ST_DECODE: begin
            pc_nxt = pc + 1'b1;
            st_nxt = ST_EXEC;
         end
         ST_EXEC: begin
            st_nxt = ST_FETCH;
            if (is_imm || is_reg) begin
               alu_start = 1'b1;
               st_nxt    = ST_ALU;
            end else if (is_undef) begin
               illegal_nxt = 1'b1;
               st_nxt      = ST_HALT;
            end else begin
               case (ir.opc)
                  OP_LD_ABS, OP_LD_DSP, OP_LD_IDX, OP_POP: begin
                     mem_rd   = 1'b1;
                     mem_addr = eff_addr;
                     st_nxt   = ST_LOADWB;
                  end
                  OP_ST_ABS, OP_ST_DSP, OP_ST_IDX: begin
                     mem_wr   = 1'b1;
                     mem_addr = eff_addr;
                  end
                  OP_JMP: pc_nxt = zext_d;
                  OP_JNZ: if (rv1 != '0) pc_nxt = zext_d;
                  OP_JZ:  if (rv1 == '0) pc_nxt = zext_d;
                  OP_LINK: begin
                     rf_we   = 1'b1;
                     rf_wval = pc;
                     pc_nxt  = zext_d;
                  end
                  OP_RET: pc_nxt = rv1;
                  OP_PUSH: begin
                     rf_we   = 1'b1;
                     rf_wval = rv1 + 1'b1;
                     st_nxt  = ST_PUSHST;
                  end
                  OP_TRAP: begin
                     if (ir.dfield == TRAP_STOP)  st_nxt = ST_HALT;
                     if (ir.dfield == TRAP_PRINT) pv_nxt = 1'b1;
                  end
                  default: ;
               endcase
            end
         end
         ST_ALU: begin
            if (alu_done) begin
               rf_we  = 1'b1;
               st_nxt = ST_FETCH;
            end
         end
         ST_LOADWB: begin
            rf_we   = 1'b1;
            rf_wsel = (ir.opc == OP_POP) ? ir.rb : ir.ra;
            rf_wval = mem_rdata;
            st_nxt  = (ir.opc == OP_POP) ? ST_POPDEC : ST_FETCH;
         end
         ST_PUSHST: begin
            mem_wr    = 1'b1;
            mem_addr  = rv1;
            mem_wdata = rv2;
            st_nxt    = ST_FETCH;
         end
         ST_POPDEC: begin
            rf_we   = 1'b1;
            rf_wval = rv1 - 1'b1;
            st_nxt  = ST_FETCH;
         end
         default: st_nxt = ST_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_FETCH;
         pc          <= '0;
         ir          <= '0;
         illegal_q   <= 1'b0;
         print_valid <= 1'b0;
         print_data  <= '0;
      end else begin
         st          <= st_nxt;
         pc          <= pc_nxt;
         illegal_q   <= illegal_nxt;
         print_valid <= pv_nxt;
         if (st == ST_DECODE) ir <= mem_rdata;
         if (pv_nxt)          print_data <= rv1;
      end
   end

   assign halted  = (st == ST_HALT);
   assign illegal = illegal_q;

   // R12: a single port, never read and write in one cycle
   p_rdwr_excl_r12: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
   // R10: a stopped core stays stopped
   p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted);
   // R10: no memory traffic once stopped
   p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !(mem_rd || mem_wr));
   // R10: print strobe lasts one cycle
   p_print_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) print_valid |=> !print_valid);
   // R11: an undefined opcode always leaves the core stopped
   p_illegal_halts_r11: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> halted);
   // R2: ALU completion only arrives while the sequencer waits for it
   p_alu_done_wait_r2: assert property (@(posedge clk) disable iff (!rst_n) alu_done |-> (st == ST_ALU));

endmodule

// File: tb/tb_tac_core.sv
module tb_tac_core;
   localparam int MEMW = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, print_data;
   logic [31:0] mem_rdata = '0;
   logic        mem_rd, mem_wr, halted, illegal, print_valid;

   always #2 clk = ~clk;   // 250 MHz

   tac_core #(.ALU_LAT(3)) dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted), .illegal(illegal),
      .print_valid(print_valid), .print_data(print_data)
   );

   logic [31:0] mem [MEMW];
   logic [31:0] last_wr_addr;
   int          n_chk = 0, n_fail = 0, n_print = 0, halt_acc = 0, cycles = 0;
   logic [31:0] plog [4];

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
      if (mem_wr) begin
         mem[mem_addr[9:0]] = mem_wdata;
         last_wr_addr = mem_addr;
      end
   end

   always @(negedge clk) begin
      if (rst_n && print_valid) begin
         if (n_print < 4) plog[n_print] = print_data;
         n_print = n_print + 1;
      end
      if (rst_n && halted && (mem_rd || mem_wr)) halt_acc = halt_acc + 1;
   end

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cycles > 195000) begin
         n_chk  = n_chk + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: act=%0d cycles exp=<195000", cycles);
         finish_up();
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc(int op, int a, int b, logic [15:0] d);
      return {6'(op), 5'(a), 5'(b), d};
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < MEMW; i++) mem[i] = '0;
      n_print  = 0;
      halt_acc = 0;
      last_wr_addr = '0;
   endtask

   task automatic run_prog(input string req);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
      if (!halted) check(1'b0, {req, " run did not stop"}, {31'd0, halted}, 32'd1);
   endtask

   function automatic logic [31:0] ref_alu(int f, logic [31:0] a, logic [31:0] b);
      logic signed [31:0] sa, sb;
      sa = a; sb = b;
      case (f)
         0:  return a + b;
         1:  return a - b;
         2:  return a * b;
         3:  return (b == 0) ? 32'd0 : 32'(sa / sb);
         4:  return a & b;
         5:  return a | b;
         6:  return a ^ b;
         7:  return {31'd0, a == b};
         8:  return {31'd0, a != b};
         9:  return {31'd0, sa <  sb};
         10: return {31'd0, sa <= sb};
         11: return {31'd0, sa >  sb};
         12: return {31'd0, sa >= sb};
         13: return a << b[4:0];
         14: return a >> b[4:0];
         default: return (b == 0) ? 32'd0 : 32'(sa % sb);
      endcase
   endfunction

   logic [31:0] av [6];
   logic [31:0] bv [6];

   initial begin
      av = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'd7, 32'h7FFF_FFFF, 32'h8000_0000};
      bv = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'd3, 32'hFFFF_FFFB, 32'd33};

      // R12: reset state and first fetch
      clear_mem();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(!halted && !illegal && !print_valid && !mem_wr, "R12 outputs idle in reset",
            {28'd0, halted, illegal, print_valid, mem_wr}, 32'd0);
      rst_n = 1'b1;
      check(mem_rd && mem_addr == 32'd0, "R12 first fetch at word 0", mem_addr, 32'd0);

      // R2 / R3: full operation sweep, register and immediate forms
      for (int f = 0; f < 16; f++) begin
         for (int form = 0; form < 2; form++) begin
            for (int ia = 0; ia < 6; ia++) begin
               for (int ib = 0; ib < 6; ib++) begin
                  if ((f == 3 || f == 15) && av[ia] == 32'h8000_0000 && bv[ib] == 32'hFFFF_FFFF) continue;
                  clear_mem();
                  mem[200] = av[ia];
                  mem[201] = bv[ib];
                  mem[0] = enc(1, 2, 0, 16'd200);
                  mem[1] = enc(1, 3, 0, 16'd201);
                  mem[2] = (form == 0) ? enc(32 + f, 4, 2, 16'd3) : enc(10 + f, 4, 2, bv[ib][15:0]);
                  mem[3] = enc(3, 4, 0, 16'd202);
                  mem[4] = enc(51, 0, 0, 16'd0);
                  run_prog(form == 0 ? "R2" : "R3");
                  check(mem[202] == ref_alu(f, av[ia], bv[ib]) && !illegal,
                        form == 0 ? "R2 register-form result" : "R3 immediate-form result",
                        mem[202], ref_alu(f, av[ia], bv[ib]));
               end
            end
         end
      end

      // R1: writes to register 0 are dropped, reads give zero
      clear_mem();
      mem[200] = 32'd77;
      mem[0] = enc(1, 2, 0, 16'd200);
      mem[1] = enc(10, 0, 2, 16'd5);
      mem[2] = enc(3, 0, 0, 16'd201);
      mem[3] = enc(32, 5, 0, 16'd2);
      mem[4] = enc(3, 5, 0, 16'd202);
      mem[5] = enc(51, 0, 0, 16'd0);
      mem[201] = 32'hDEAD_BEEF;
      run_prog("R1");
      check(mem[201] == 32'd0, "R1 register 0 after write", mem[201], 32'd0);
      check(mem[202] == 32'd77, "R1 r0 as zero operand", mem[202], 32'd77);

      // R4: absolute address is zero-extended
      clear_mem();
      mem[311] = 32'd41;
      mem[0] = enc(1, 5, 0, 16'd311);
      mem[1] = enc(3, 5, 0, 16'd312);
      mem[2] = enc(3, 0, 0, 16'hFFFF);
      mem[3] = enc(51, 0, 0, 16'd0);
      run_prog("R4");
      check(mem[312] == 32'd41, "R4 absolute load/store", mem[312], 32'd41);
      check(last_wr_addr == 32'h0000_FFFF, "R4 absolute address zero-extended", last_wr_addr, 32'h0000_FFFF);

      // R5: displacement with negative and positive offsets
      clear_mem();
      mem[302] = 32'd99;
      mem[0] = enc(10, 2, 0, 16'd300);
      mem[1] = enc(10, 3, 0, 16'd55);
      mem[2] = enc(4, 3, 2, 16'hFFFB);
      mem[3] = enc(2, 4, 2, 16'd2);
      mem[4] = enc(3, 4, 0, 16'd310);
      mem[5] = enc(51, 0, 0, 16'd0);
      run_prog("R5");
      check(mem[295] == 32'd55, "R5 displacement store at base-5", mem[295], 32'd55);
      check(mem[310] == 32'd99, "R5 displacement load at base+2", mem[310], 32'd99);

      // R6: index mode with a high address
      clear_mem();
      mem[0] = enc(10, 2, 0, 16'd1);
      mem[1] = enc(23, 2, 2, 16'd28);
      mem[2] = enc(10, 3, 0, 16'd400);
      mem[3] = enc(10, 4, 0, 16'hFFF7);
      mem[4] = enc(49, 4, 2, 16'd3);
      mem[5] = enc(48, 5, 3, 16'd0);
      mem[6] = enc(3, 5, 0, 16'd401);
      mem[7] = enc(51, 0, 0, 16'd0);
      run_prog("R6");
      check(mem[400] == 32'hFFFF_FFF7, "R6 index store data", mem[400], 32'hFFFF_FFF7);
      check(mem[401] == 32'hFFFF_FFF7, "R6 index load", mem[401], 32'hFFFF_FFF7);
      clear_mem();
      mem[0] = enc(10, 2, 0, 16'd1);
      mem[1] = enc(23, 2, 2, 16'd28);
      mem[2] = enc(10, 3, 0, 16'd400);
      mem[3] = enc(49, 0, 2, 16'd3);
      mem[4] = enc(51, 0, 0, 16'd0);
      run_prog("R6");
      check(last_wr_addr == 32'h1000_0190, "R6 full 32-bit index address", last_wr_addr, 32'h1000_0190);

      // R7: unconditional and both conditional jumps, taken and not taken
      clear_mem();
      mem[0]  = enc(10, 2, 0, 16'd0);
      mem[1]  = enc(8, 2, 0, 16'd10);
      mem[2]  = enc(9, 2, 0, 16'd5);
      mem[3]  = enc(10, 6, 0, 16'd1);
      mem[4]  = enc(51, 0, 0, 16'd0);
      mem[5]  = enc(10, 3, 0, 16'd7);
      mem[6]  = enc(8, 3, 0, 16'd9);
      mem[7]  = enc(10, 6, 0, 16'd2);
      mem[8]  = enc(51, 0, 0, 16'd0);
      mem[9]  = enc(6, 0, 0, 16'd12);
      mem[10] = enc(10, 6, 0, 16'd3);
      mem[11] = enc(51, 0, 0, 16'd0);
      mem[12] = enc(10, 6, 0, 16'd9);
      mem[13] = enc(9, 3, 0, 16'd10);
      mem[14] = enc(3, 6, 0, 16'd500);
      mem[15] = enc(51, 0, 0, 16'd0);
      run_prog("R7");
      check(mem[500] == 32'd9, "R7 jump path", mem[500], 32'd9);

      // R8: link value and return
      clear_mem();
      mem[0]  = enc(7, 7, 0, 16'd20);
      mem[1]  = enc(3, 7, 0, 16'd501);
      mem[2]  = enc(10, 8, 0, 16'd5);
      mem[3]  = enc(3, 8, 0, 16'd502);
      mem[4]  = enc(51, 0, 0, 16'd0);
      mem[20] = enc(3, 7, 0, 16'd503);
      mem[21] = enc(50, 7, 0, 16'd0);
      run_prog("R8");
      check(mem[503] == 32'd1, "R8 link holds next address", mem[503], 32'd1);
      check(mem[501] == 32'd1 && mem[502] == 32'd5, "R8 return resumes after link", mem[502], 32'd5);

      // R9: push/pop with r9 as stack pointer
      clear_mem();
      mem[0]  = enc(10, 9, 0, 16'd600);
      mem[1]  = enc(10, 2, 0, 16'd11);
      mem[2]  = enc(10, 3, 0, 16'd22);
      mem[3]  = enc(52, 9, 2, 16'd0);
      mem[4]  = enc(52, 9, 3, 16'd0);
      mem[5]  = enc(53, 9, 4, 16'd0);
      mem[6]  = enc(3, 9, 0, 16'd610);
      mem[7]  = enc(3, 4, 0, 16'd611);
      mem[8]  = enc(53, 9, 5, 16'd0);
      mem[9]  = enc(3, 5, 0, 16'd612);
      mem[10] = enc(3, 9, 0, 16'd613);
      mem[11] = enc(51, 0, 0, 16'd0);
      run_prog("R9");
      check(mem[601] == 32'd11 && mem[602] == 32'd22, "R9 push pre-increments", mem[602], 32'd22);
      check(mem[610] == 32'd601 && mem[611] == 32'd22, "R9 pop then decrement", mem[610], 32'd601);
      check(mem[612] == 32'd11 && mem[613] == 32'd600, "R9 second pop", mem[613], 32'd600);

      // R10: print trap, ignored trap code, stop
      clear_mem();
      mem[0] = enc(10, 2, 0, 16'hFFFD);
      mem[1] = enc(51, 2, 0, 16'd1);
      mem[2] = enc(51, 2, 0, 16'd7);
      mem[3] = enc(10, 3, 0, 16'd44);
      mem[4] = enc(51, 3, 0, 16'd1);
      mem[5] = enc(51, 0, 0, 16'd0);
      mem[6] = enc(3, 3, 0, 16'd700);
      run_prog("R10");
      repeat (20) @(negedge clk);
      check(n_print == 2, "R10 one strobe per print trap", n_print, 32'd2);
      check(plog[0] == 32'hFFFF_FFFD && plog[1] == 32'd44, "R10 print values", plog[1], 32'd44);
      check(halted && mem[700] == 32'd0 && halt_acc == 0, "R10 stop is final", halt_acc, 32'd0);

      // R11: no-ops with junk fields, then an undefined opcode
      clear_mem();
      mem[0] = enc(0, 3, 4, 16'h1234);
      mem[1] = enc(5, 3, 4, 16'hFFFF);
      mem[2] = enc(10, 3, 3, 16'd8);
      mem[3] = enc(3, 3, 0, 16'd710);
      mem[4] = enc(27, 3, 0, 16'd711);
      mem[5] = enc(3, 3, 0, 16'd711);
      run_prog("R11");
      check(mem[710] == 32'd8, "R11 no-op leaves r3 untouched", mem[710], 32'd8);
      check(illegal && halted && mem[711] == 32'd0, "R11 opcode 27 stops core", {31'd0, illegal}, 32'd1);
      for (int op = 26; op < 64; op++) begin
         if (op > 31 && op < 54) continue;
         clear_mem();
         mem[0] = enc(op, 3, 3, 16'd1);
         mem[1] = enc(10, 3, 0, 16'd1);
         mem[2] = enc(3, 3, 0, 16'd712);
         mem[3] = enc(51, 0, 0, 16'd0);
         run_prog("R11");
         check(illegal && mem[712] == 32'd0, "R11 undefined opcode sweep", op, 32'd0);
      end

      finish_up();
   end
endmodule